// File: doc/BRIEF.md
# PWM Timer with Shared Compare/Capture Register

This block is a 16-bit timer peripheral with a byte-wide register interface. A counter advances on a tick from a power-of-two prescaler. When the counter reaches a reload value, it wraps back to 1. In PWM mode, the count is compared against a 16-bit value held in a high/low byte register pair. A match toggles the primary output, and the reload returns that output to the level chosen by a polarity bit. A complementary output follows the inverse of the primary output, held low for a programmable number of clocks after each primary transition.

In the two capture modes, the same register pair no longer serves as a compare value. It latches the running count when a synchronized rising edge arrives on the capture input. Both bytes are written in one clock, so a byte-by-byte read never mixes two captures. In capture/compare mode the capture also restarts the count. A one-cycle interrupt pulse is raised on capture, compare or reload events, filtered by a configuration field. A status bit records whether the last pulse came from a capture.

Top module: `pwm_capture_timer`

## Requirements
- R1: After reset every register reads 0, `pwm_out` is low, `pwm_n_out` is high and `irq` is low.
- R2: The counter advances once every 2^P clocks, where P is the prescale field ctrl1[5:3]. Writing ctrl1 with the enable bit [7] set while the timer is stopped loads the count with 1.
- R3: In PWM mode, a tick on which the count equals the compare pair {addr 0, addr 1} toggles `pwm_out` and is a compare event. PWM mode is mode code 4'b0001.
- R4: A tick on which the count equals the reload pair {addr 2, addr 3} loads the count with 1 and is a reload event. In PWM mode it also returns `pwm_out` to the polarity level.
- R5: The polarity bit ctrl1[6] sets the level of `pwm_out` at start, at every reload and whenever the timer is stopped or not in PWM mode.
- R6: In one-shot mode (code 4'b0000), the reload event clears the enable bit ctrl1[7], so the count stays at 1.
- R7: In capture mode (code 4'b0011), the count is written into both compare bytes in one clock. The edge is detected three clocks after `cap_in` rises (two synchronizer stages plus edge detect).
- R8: In capture/compare mode (code 4'b1010), a capture also loads the count with 1.
- R9: Status bit ctrl0[0] becomes 1 when an interrupt pulse comes from a capture. It becomes 0 when an interrupt pulse comes from a compare or reload event.
- R10: The interrupt filter ctrl0[6:5] selects which events give a one-clock `irq` pulse on the edge after the event: 0 or 3 passes all events, 1 passes captures only, 2 passes compare/reload only.
- R11: With deadband D = ctrl0[3:1], `pwm_n_out` is forced low for D clocks after each change of `pwm_out`. After that it equals the inverse of `pwm_out`.
- R12: The mode code is {ctrl0[7], ctrl1[2:0]}. The counter reads at addresses 6 (high) and 7 (low). Ctrl0 is at address 4 and ctrl1 at address 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| cap_in | input | 1 | Asynchronous capture input |
| pwm_out | output | 1 | Primary PWM output |
| pwm_n_out | output | 1 | Complementary output with deadband |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
PWM runs with polarity 0 and polarity 1 show that a compare toggles the output and a reload restores the starting level rather than toggling again. A run with a nonzero deadband and a capture-only filter separates the delayed complementary output from the plain inverse, and shows that compare and reload pulses are suppressed. One-shot runs at two prescale settings tell the tick rate apart from the count rate. Capture runs under two filter settings show whether a later reload clears the status bit, and a capture/compare run shows whether the capture restarts the count.

// File: rtl/pct_pkg.sv
package pct_pkg;
   typedef enum logic [3:0] {
      MODE_ONESHOT = 4'b0000,
      MODE_PWM     = 4'b0001,
      MODE_CAPT    = 4'b0011,
      MODE_CAPCMP  = 4'b1010
   } tmode_e;

   localparam logic [2:0] A_CMP_HI = 3'd0;
   localparam logic [2:0] A_CMP_LO = 3'd1;
   localparam logic [2:0] A_RLD_HI = 3'd2;
   localparam logic [2:0] A_RLD_LO = 3'd3;
   localparam logic [2:0] A_CTL0   = 3'd4;
   localparam logic [2:0] A_CTL1   = 3'd5;
   localparam logic [2:0] A_CNT_HI = 3'd6;
   localparam logic [2:0] A_CNT_LO = 3'd7;

   localparam logic [1:0] IRQ_CAP_ONLY = 2'b01;
   localparam logic [1:0] IRQ_OTH_ONLY = 2'b10;
endpackage

// File: rtl/pct_prescale.sv
module pct_prescale #(
   parameter int PRE_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] exp_sel,
   output logic             tick
);
   localparam int PC_W = (1 << PRE_W) - 1;

   logic [PC_W-1:0] pc;
   logic [PC_W-1:0] mask;

   assign mask = (PC_W'(1) << exp_sel) - PC_W'(1);
   assign tick = run && ((pc & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pc <= '0;
      else if (!run) pc <= '0;
      else          pc <= pc + PC_W'(1);
   end
endmodule

// File: rtl/pct_edge.sv
module pct_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], din};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pct_deadband.sv
module pct_deadband #(
   parameter int DB_W   = 3,
   parameter bit HAS_DB = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pwm_next,
   input  logic [DB_W-1:0] delay,
   output logic            pwm_out,
   output logic            pwm_n_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_out <= 1'b0;
      else        pwm_out <= pwm_next;
   end

   generate
      if (HAS_DB) begin : g_db
         logic [DB_W-1:0] hold;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  hold <= '0;
            else if (pwm_next != pwm_out) hold <= delay;
            else if (hold != '0)          hold <= hold - DB_W'(1);
         end
         assign pwm_n_out = (hold == '0) ? ~pwm_out : 1'b0;

         // R11: complementary output is held low right after a transition
         a_r11_deadband_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ((pwm_next != pwm_out) && (delay != '0)) |=> !pwm_n_out);
      end else begin : g_nodb
         logic unused_delay;
         assign unused_delay = ^delay;
         assign pwm_n_out = ~pwm_out;
      end
   endgenerate
endmodule

// File: rtl/pwm_capture_timer.sv
module pwm_capture_timer
   import pct_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PRE_W       = 3,
   parameter int DB_W        = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       cap_in,
   output logic       pwm_out,
   output logic       pwm_n_out,
   output logic       irq
);
   generate
      if (CNT_W != 16) begin : g_bad_cnt
         $error("CNT_W must be 16 for the two-byte register layout");
      end
      if (PRE_W < 1 || PRE_W > 3) begin : g_bad_pre
         $error("PRE_W must be 1..3");
      end
      if (DB_W < 1 || DB_W > 3) begin : g_bad_db
         $error("DB_W must be 1..3");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cmp_q, rld_q, cnt_q;
   logic [7:0]       ctl0_q, ctl1_q;

   tmode_e mode;
   logic   en, pol, run, mode_known, start, tick, rise;
   logic   pwm_mode, cap_mode, at_rld, at_cmp;
   logic   cap_ev, rld_ev, cmp_ev, irq_cap, irq_oth, pwm_next;
   logic   wr_c0, wr_c1;
   logic [1:0] icfg;

   assign mode     = tmode_e'({ctl0_q[7], ctl1_q[2:0]});
   assign en       = ctl1_q[7];
   assign pol      = ctl1_q[6];
   assign icfg     = ctl0_q[6:5];
   assign wr_c0    = wr_en && (addr == A_CTL0);
   assign wr_c1    = wr_en && (addr == A_CTL1);
   assign start    = wr_c1 && wdata[7] && !en;

   always_comb begin
      case (mode)
         MODE_ONESHOT, MODE_PWM, MODE_CAPT, MODE_CAPCMP: mode_known = 1'b1;
         default:                                        mode_known = 1'b0;
      endcase
   end

   assign run      = en && mode_known;
   assign pwm_mode = (mode == MODE_PWM);
   assign cap_mode = (mode == MODE_CAPT) || (mode == MODE_CAPCMP);
   assign at_rld   = (cnt_q == rld_q);
   assign at_cmp   = (cnt_q == cmp_q);

   pct_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run),
      .exp_sel(ctl1_q[3 +: PRE_W]), .tick(tick));

   pct_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(rise));

   assign cap_ev  = run && cap_mode && rise;
   assign rld_ev  = tick && at_rld;
   assign cmp_ev  = tick && pwm_mode && at_cmp && !at_rld;
   assign irq_cap = cap_ev && (icfg != IRQ_OTH_ONLY);
   assign irq_oth = (rld_ev || cmp_ev) && (icfg != IRQ_CAP_ONLY);

   always_comb begin
      if (start)                 pwm_next = wdata[6];
      else if (!run || !pwm_mode) pwm_next = pol;
      else if (rld_ev)            pwm_next = pol;
      else if (cmp_ev)            pwm_next = ~pwm_out;
      else                        pwm_next = pwm_out;
   end

   pct_deadband #(.DB_W(DB_W), .HAS_DB(1'b1)) u_db (
      .clk(clk), .rst_n(rst_n), .pwm_next(pwm_next),
      .delay(ctl0_q[DB_W:1]), .pwm_out(pwm_out), .pwm_n_out(pwm_n_out));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         rld_q  <= '0;
         cnt_q  <= '0;
         ctl0_q <= '0;
         ctl1_q <= '0;
         irq    <= 1'b0;
      end else begin
         if (wr_en) begin
            case (addr)
               A_CMP_HI: cmp_q[15:8] <= wdata;
               A_CMP_LO: cmp_q[7:0]  <= wdata;
               A_RLD_HI: rld_q[15:8] <= wdata;
               A_RLD_LO: rld_q[7:0]  <= wdata;
               A_CTL0:   ctl0_q      <= wdata;
               A_CTL1:   ctl1_q      <= wdata;
               default: ;
            endcase
         end
         if (cap_ev) cmp_q <= cnt_q;
         if (rld_ev && mode == MODE_ONESHOT && !wr_c1) ctl1_q[7] <= 1'b0;
         if (irq_cap)      ctl0_q[0] <= 1'b1;
         else if (irq_oth) ctl0_q[0] <= 1'b0;

         if (start)                              cnt_q <= CNT_W'(1);
         else if (cap_ev && mode == MODE_CAPCMP) cnt_q <= CNT_W'(1);
         else if (rld_ev)                        cnt_q <= CNT_W'(1);
         else if (tick)                          cnt_q <= cnt_q + CNT_W'(1);

         irq <= irq_cap || irq_oth;
      end
   end

   always_comb begin
      case (addr)
         A_CMP_HI: rdata = cmp_q[15:8];
         A_CMP_LO: rdata = cmp_q[7:0];
         A_RLD_HI: rdata = rld_q[15:8];
         A_RLD_LO: rdata = rld_q[7:0];
         A_CTL0:   rdata = ctl0_q;
         A_CTL1:   rdata = ctl1_q;
         A_CNT_HI: rdata = cnt_q[15:8];
         default:  rdata = cnt_q[7:0];
      endcase
   end

   // R3: compare match flips the primary output on the next edge
   a_r3_cmp_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_ev |=> (pwm_out != $past(pwm_out)));
   // R4: reload restarts the count at 1
   a_r4_reload_to_one: assert property (@(posedge clk) disable iff (!rst_n)
      rld_ev |=> (cnt_q == CNT_W'(1)));
   // R6: one-shot stops itself at reload
   a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (rld_ev && mode == MODE_ONESHOT && !wr_c1) |=> !ctl1_q[7]);
   // R7: capture stores the count that was running at the edge
   a_r7_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ev |=> (cmp_q == $past(cnt_q)));
   // R9: capture interrupt marks the status bit
   a_r9_status_set: assert property (@(posedge clk) disable iff (!rst_n)
      irq_cap |=> ctl0_q[0]);
   // R10: pulse lasts one clock unless another event follows
   a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(irq_cap) || $past(irq_oth)));
endmodule

// File: tb/tb_pwm_capture_timer.sv
module tb_pwm_capture_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       cap_in = 1'b0;
   logic       pwm_out, pwm_n_out, irq;

   int n_tests = 0;
   int n_fail  = 0;
   int irq_seen = 0;
   bit done = 1'b0;

   logic [2:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   pwm_capture_timer dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .cap_in(cap_in), .pwm_out(pwm_out),
      .pwm_n_out(pwm_n_out), .irq(irq));

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected {irq,pwm,pwm_n} per cycle
   always @(negedge clk) begin
      if (irq === 1'b1) irq_seen++;
      if (exp_q.size() > 0) begin
         logic [2:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, {13'd0, irq, pwm_out, pwm_n_out}, {13'd0, e});
      end
   end

   task automatic push(input logic [2:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic drain();
      wait (exp_q.size() == 0);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(posedge clk); #1;
      addr = a;
      @(negedge clk);
      d = rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pwm_out", {15'd0, pwm_out}, 16'd0);
      check("R1 pwm_n_out", {15'd0, pwm_n_out}, 16'd1);
      check("R1 irq", {15'd0, irq}, 16'd0);
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         check("R1 register reset", {8'd0, v}, 16'd0);
      end

      // R3 R4 basic PWM, polarity 0
      wr(3'd0, 8'h00); wr(3'd1, 8'h02); wr(3'd2, 8'h00); wr(3'd3, 8'h05);
      wr(3'd5, 8'h81);
      push(3'b001, "R2 start"); push(3'b001, "R3 before match");
      push(3'b110, "R3 compare toggle"); push(3'b010, "R3 hold");
      push(3'b010, "R3 hold"); push(3'b101, "R4 reload level");
      push(3'b001, "R4 after reload"); push(3'b110, "R3 second match");
      drain();
      wr(3'd5, 8'h00);

      // R5 polarity 1
      wr(3'd5, 8'hC1);
      push(3'b010, "R5 start level"); push(3'b010, "R5 hold");
      push(3'b101, "R5 compare toggle"); push(3'b001, "R5 hold");
      push(3'b001, "R5 hold"); push(3'b110, "R5 reload level");
      push(3'b010, "R5 after reload"); push(3'b101, "R5 second match");
      drain();
      wr(3'd5, 8'h00);

      // R11 deadband 2 with R10 capture-only filter
      wr(3'd1, 8'h04); wr(3'd3, 8'h08); wr(3'd4, 8'h24);
      wr(3'd5, 8'h81);
      for (int k = 0; k < 4; k++) push(3'b001, "R11 low phase");
      push(3'b010, "R11 rise, comp low"); push(3'b010, "R11 hold");
      push(3'b010, "R11 high"); push(3'b010, "R11 high");
      push(3'b000, "R11 fall, dead 1"); push(3'b000, "R11 fall, dead 2");
      push(3'b001, "R11 comp released"); push(3'b001, "R10 no compare irq");
      drain();
      wr(3'd5, 8'h00);

      // R6 one-shot, prescale 0
      wr(3'd4, 8'h00); wr(3'd3, 8'h03);
      wr(3'd5, 8'h80);
      for (int k = 0; k < 6; k++)
         push((k == 3) ? 3'b101 : 3'b001, "R6 one-shot irq timing");
      drain();
      rd(3'd5, v); check("R6 enable cleared", {8'd0, v}, 16'h0000);
      rd(3'd7, v); check("R6 count parked at 1", {8'd0, v}, 16'h0001);

      // R2 one-shot, prescale 1 (tick every 2 clocks)
      wr(3'd5, 8'h88);
      for (int k = 0; k < 9; k++)
         push((k == 6) ? 3'b101 : 3'b001, "R2 prescaled irq timing");
      drain();

      // R7 R9 capture, filter all
      wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'h00); wr(3'd3, 8'd20);
      wr(3'd4, 8'h00);
      irq_seen = 0;
      wr(3'd5, 8'h83);
      repeat (5) @(posedge clk);
      #1 cap_in = 1'b1;
      repeat (3) @(posedge clk);
      rd(3'd0, v); check("R7 captured high byte", {8'd0, v}, 16'h0000);
      rd(3'd1, v); check("R7 captured low byte", {8'd0, v}, 16'h0008);
      rd(3'd4, v); check("R9 status after capture", {8'd0, v}, 16'h0001);
      repeat (20) @(posedge clk);
      rd(3'd4, v); check("R9 status cleared by reload", {8'd0, v}, 16'h0000);
      check("R10 all events irq count", 16'(irq_seen), 16'd2);
      wr(3'd5, 8'h00);
      cap_in = 1'b0;

      // R10 capture-only filter keeps status
      wr(3'd4, 8'h20);
      repeat (4) @(posedge clk);
      irq_seen = 0;
      wr(3'd5, 8'h83);
      repeat (5) @(posedge clk);
      #1 cap_in = 1'b1;
      repeat (30) @(posedge clk);
      rd(3'd4, v); check("R10 reload irq filtered, status kept", {8'd0, v}, 16'h0021);
      check("R10 capture-only irq count", 16'(irq_seen), 16'd1);
      wr(3'd5, 8'h00);
      cap_in = 1'b0;

      // R8 capture/compare restarts count, R12 mode high bit
      wr(3'd4, 8'h80);
      repeat (4) @(posedge clk);
      wr(3'd5, 8'h82);
      repeat (5) @(posedge clk);
      #1 cap_in = 1'b1;
      repeat (2) @(posedge clk);
      rd(3'd7, v); check("R8 count restarted", {8'd0, v}, 16'h0001);
      rd(3'd1, v); check("R8 captured value", {8'd0, v}, 16'h0008);
      rd(3'd6, v); check("R12 count high byte", {8'd0, v}, 16'h0000);
      wr(3'd5, 8'h00);
      cap_in = 1'b0;

      finish_run();
   end
endmodule